// File: doc/BRIEF.md
# Chip-Level Preamble Detector with Error Budget

This block watches a demodulated, oversampled bit stream for the alternating training sequence that opens a packet. Every data bit arrives as four chips, each marked by a chip-valid strobe. The block keeps a sliding window of the most recent chips, one, two or three bytes long, and counts how many chips differ from an ideal alternating pattern. Both phases of the pattern are accepted, so a window that starts on a 1 bit and a window that starts on a 0 bit both qualify. When the smaller of the two mismatch counts is within a programmable budget, the block reports a detection.

A detection produces a one-cycle interrupt pulse and sets a sticky flag. The flag holds until a clear input or a restart. The receive controller drives the enable input low during its startup and gain-settling phase. It pulses restart when it wants a fresh hunt. No detection is reported until a full window of valid chips has arrived since the block was last enabled, restarted or reset. The surrounding register bank supplies the configuration inputs and resets them to enabled, two-byte window and a budget of ten.

Top module: `preamble_hunter`

## Requirements
- R1: The ideal pattern has 4 chips per bit, with bit values that alternate from one bit to the next. The newest chip sits at position 0, and a window matches in either phase. For phase A, the bit at position i is 1 when (i/4) is even. Phase B is the complement of phase A.
- R2: While `det_en` is 0, no pulse is produced and the count of filled chips returns to zero. After `det_en` rises, a full window must be collected again.
- R3: `win_sel` sets the window length: 00 gives 32 chips, 01 gives 64 chips, 10 gives 96 chips, and the reserved code 11 also gives 96 chips.
- R4: A detection needs at least as many valid chips as the window length since the most recent reset, restart or enable. This count includes the chip accepted at the current edge.
- R5: A window matches when min(mismatches against phase A, mismatches against phase B) ≤ `err_budget`. The mismatch counts cover only the selected window length.
- R6: A chip is taken in and counted only on a clock edge where `chip_vld` is 1. A match is evaluated only on such an edge.
- R7: `det_pulse` is high for exactly the one cycle after the edge that accepted a matching chip, and only when `det_flag` was 0 at that edge.
- R8: `det_flag` rises together with `det_pulse` and stays set until `flag_clr` is sampled high. If a new match occurs on the same edge as a clear, the match wins and the flag stays set. After reset both outputs are 0.
- R9: When `restart` is high at an edge, the flag is cleared and the fill count goes to zero. The chip offered at that edge is not counted and cannot produce a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_vld | input | 1 | Strobe that marks a valid chip |
| chip_in | input | 1 | Demodulated chip value |
| det_en | input | 1 | Detector enable (low during startup/AGC) |
| win_sel | input | 2 | Window length code |
| err_budget | input | 5 | Number of chip mismatches allowed across the window |
| restart | input | 1 | Begin a fresh hunt: clears the fill count and the flag |
| flag_clr | input | 1 | Clears the sticky flag |
| det_pulse | output | 1 | One-cycle detection interrupt |
| det_flag | output | 1 | Sticky detection flag |

## Verification
Every internal error shows up at the ports within one window of chips. A fill count that is too high makes the pulse appear one or more chips early. A shift register that is misaligned, or a phase that is not handled, makes a clean preamble pass silently, or makes a stream that is one mismatch over budget fire. In both cases the fault shows on the first chip after the window fills. A wrong flag priority shows up in the cycle after a clear meets a match, because the pulse then repeats or the flag drops.

// File: rtl/preamble_hunter.sv
module preamble_hunter #(
  parameter int CHIPS_PER_BIT = 4,
  parameter int WIN_BYTES_MAX = 3,
  parameter int BUDGET_W      = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                chip_vld,
  input  logic                chip_in,
  input  logic                det_en,
  input  logic [1:0]          win_sel,
  input  logic [BUDGET_W-1:0] err_budget,
  input  logic                restart,
  input  logic                flag_clr,
  output logic                det_pulse,
  output logic                det_flag
);
  localparam int BYTE_CHIPS = CHIPS_PER_BIT * 8;
  localparam int WMAX       = BYTE_CHIPS * WIN_BYTES_MAX;
  localparam int CW         = $clog2(WMAX + 1);

  logic [WMAX-1:0] win_q, win_d;
  logic [CW-1:0]   fill_q, fill_d, span;
  logic [CW-1:0]   err_a, err_b, err_min;
  logic            hit;

  assign win_d  = {win_q[WMAX-2:0], chip_in};
  assign fill_d = (fill_q == CW'(WMAX)) ? fill_q : fill_q + 1'b1;

  always_comb begin
    case (win_sel)
      2'b00:   span = CW'(BYTE_CHIPS);
      2'b01:   span = CW'(2 * BYTE_CHIPS);
      default: span = CW'(WMAX);
    endcase
  end

  always_comb begin
    err_a = '0;
    for (int i = 0; i < WMAX; i++)
      if (CW'(i) < span && win_d[i] != 1'(((i / CHIPS_PER_BIT) % 2) == 0))
        err_a = err_a + 1'b1;
  end

  assign err_b   = span - err_a;
  assign err_min = (err_a < err_b) ? err_a : err_b;
  assign hit     = chip_vld & det_en & ~restart & (fill_d >= span)
                 & (err_min <= CW'(err_budget));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q     <= '0;
      fill_q    <= '0;
      det_pulse <= 1'b0;
      det_flag  <= 1'b0;
    end else begin
      det_pulse <= hit & ~det_flag;
      if (chip_vld) win_q <= win_d;
      if (restart || !det_en) fill_q <= '0;
      else if (chip_vld)      fill_q <= fill_d;
      if (restart)       det_flag <= 1'b0;
      else if (hit)      det_flag <= 1'b1;
      else if (flag_clr) det_flag <= 1'b0;
    end
  end

  AST_PULSE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    det_pulse |-> $past(det_en) && $past(chip_vld) && !$past(restart)); // R2
  AST_PULSE_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    det_pulse |-> $past(fill_q) + 1 >= $past(span) || $past(fill_q) == CW'(WMAX)); // R4
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    det_pulse |=> !det_pulse); // R7
  AST_PULSE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    det_pulse |-> det_flag); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (det_flag && !flag_clr && !restart) |=> det_flag); // R8
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !det_flag && !det_pulse); // R9
endmodule

// File: tb/tb_preamble_hunter.sv
`timescale 1ns/1ps
module tb_preamble_hunter;
  logic clk = 0, rst_n = 0;
  logic chip_vld = 0, chip_in = 0, det_en = 1, restart = 0, flag_clr = 0;
  logic [1:0] win_sel = 2'b00;
  logic [4:0] err_budget = 5'd0;
  logic det_pulse, det_flag;
  int checks = 0, fails = 0;

  logic [95:0] m_win = '0;
  int m_fill = 0;
  bit m_flag = 0;

  preamble_hunter dut (.*);

  always #2 clk = ~clk;

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  function automatic int span_of(input logic [1:0] s);
    return (s == 2'b00) ? 32 : (s == 2'b01) ? 64 : 96;
  endfunction

  function automatic bit ideal(input int pos);
    return ((pos / 4) % 2) == 0;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit v, input bit c, input string tag);
    logic [95:0] nw;
    int nf, ea, sp;
    bit hit, ep;
    @(negedge clk);
    chip_vld = v; chip_in = c;
    nw = {m_win[94:0], c};
    nf = (m_fill == 96) ? 96 : m_fill + 1;
    sp = span_of(win_sel);
    ea = 0;
    for (int i = 0; i < sp; i++) if (nw[i] != ideal(i)) ea++;
    hit = v && det_en && !restart && nf >= sp &&
          (((ea < sp - ea) ? ea : sp - ea) <= int'(err_budget));
    ep = hit && !m_flag;
    if (v) m_win = nw;
    if (restart || !det_en) m_fill = 0; else if (v) m_fill = nf;
    if (restart) m_flag = 0; else if (hit) m_flag = 1; else if (flag_clr) m_flag = 0;
    @(posedge clk); #1;
    chk({tag, " pulse"}, det_pulse, ep);
    chk({tag, " flag"}, det_flag, m_flag);
    restart = 0; flag_clr = 0;
  endtask

  task automatic fresh();
    restart = 1;
    step(0, 0, "R9");
  endtask

  task automatic stream(input int n, input bit ph, input int start, input string tag);
    for (int k = 0; k < n; k++) step(1, ideal(start + k) ^ ph, tag);
  endtask

  initial begin
    int unsigned seed;
    seed = 32'd12345;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1;
    chk("R8 reset", det_pulse, 1'b0);
    chk("R8 reset", det_flag, 1'b0);
    rst_n = 1;

    win_sel = 2'b00; err_budget = 0;
    fresh(); stream(40, 0, 0, "R4");
    fresh(); stream(40, 1, 0, "R1");
    fresh(); stream(20, 0, 0, "R6");
    repeat (5) step(0, 1, "R6");
    stream(20, 0, 20, "R6");

    win_sel = 2'b01; err_budget = 3;
    fresh();
    for (int k = 0; k < 70; k++) step(1, ideal(k) ^ (k == 5 || k == 9 || k == 13), "R5");
    err_budget = 2;
    fresh();
    for (int k = 0; k < 70; k++) step(1, ideal(k) ^ (k == 5 || k == 9 || k == 13), "R5");

    win_sel = 2'b10; err_budget = 0; fresh(); stream(100, 0, 0, "R3");
    win_sel = 2'b11; fresh(); stream(100, 1, 3, "R3");

    win_sel = 2'b00; det_en = 0; fresh(); stream(40, 0, 0, "R2");
    det_en = 1; stream(40, 0, 40, "R2");
    det_en = 0; step(1, 0, "R2"); det_en = 1; stream(34, 0, 0, "R2");

    flag_clr = 1; step(1, ideal(34), "R8");
    flag_clr = 1; step(0, 0, "R8");
    stream(4, 0, 35, "R7");
    restart = 1; step(1, ideal(39), "R9");
    stream(33, 0, 40, "R9");

    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 199) == 0) begin
        win_sel = 2'($urandom_range(0, 3));
        err_budget = 5'($urandom_range(0, 8));
      end
      det_en   = ($urandom_range(0, 99) != 0);
      restart  = ($urandom_range(0, 299) == 0);
      flag_clr = ($urandom_range(0, 19) == 0);
      step($urandom_range(0, 3) != 0,
           ideal(n) ^ ($urandom_range(0, 49) == 0), "R5 random");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule